// File: doc/BRIEF.md
# Nanosecond-to-Clock Timing Encoder

This block turns drive timing given in nanoseconds into the clock counts a two-drive parallel disk port controller needs. Each of two drives supplies an address setup time, an active pulse time and a total cycle time, together with a flag saying whether the drive is attached. One bus frequency in MHz serves both drives. Every time is converted to clocks by exact integer ceiling division, and each count is then held inside its own legal window.

The recovery time is what remains of the cycle once setup and active time are taken out; a negative remainder counts as zero. A detached drive is given the smallest legal counts. The two drives share one setup count, the larger of the two. The results are packed into one cycle byte per drive and one shared miscellaneous byte carrying the setup count, a fixed ready count and a read-prefetch enable.

Software or a sequencer places the nanosecond values on the inputs and pulses `start`. Two clocks later `done` pulses for one cycle, and the three bytes take their new values at that same moment. They then hold until the next `start`.

Top module: `ns_timing_encoder`

## Requirements
- R1: Each clock count before clamping is floor((ns × MHz + 999) / 1000), with no overflow for any 16-bit ns and 8-bit MHz value (100 ns at 10 MHz gives 1, 101 ns gives 2, 80 ns at 40 MHz gives 4).
- R2: Recovery in ns is cycle − setup − active, computed before conversion to clocks; a negative result is taken as 0 ns.
- R3: The setup count is clamped to the range 1 to 4.
- R4: The active count is clamped to the range 1 to 16.
- R5: The recovery count is clamped to the range 2 to 17.
- R6: A drive whose present input is 0 gets setup 1, active 1 and recovery 2, whatever its ns inputs hold.
- R7: The shared setup count is the larger of the two drives' setup counts.
- R8: Each drive's cycle byte holds active − 1 in bits 7:4 and recovery − 2 in bits 3:0.
- R9: The miscellaneous byte holds the prefetch enable (1 by default) in bit 6, shared setup − 1 in bits 5:4 and ready − 2 in bits 3:1, with ready 2 by default; bits 7 and 0 are 0.
- R10: A `start` sampled high at a rising edge makes `done` high for exactly the cycle that follows the second rising edge after it, and the output bytes change at that edge.
- R11: After reset, `done` is 0 and all three output bytes are 0.
- R12: When `start` is low, input changes do not affect the output bytes, and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample the inputs and begin a conversion |
| bus_mhz | input | 8 | Bus frequency in MHz |
| drv0_present | input | 1 | Drive 0 is attached |
| drv0_setup_ns | input | 16 | Drive 0 address setup time, ns |
| drv0_active_ns | input | 16 | Drive 0 active pulse time, ns |
| drv0_cycle_ns | input | 16 | Drive 0 total cycle time, ns |
| drv1_present | input | 1 | Drive 1 is attached |
| drv1_setup_ns | input | 16 | Drive 1 address setup time, ns |
| drv1_active_ns | input | 16 | Drive 1 active pulse time, ns |
| drv1_cycle_ns | input | 16 | Drive 1 total cycle time, ns |
| done | output | 1 | One-cycle pulse: new bytes are valid |
| drv0_cycle_byte | output | 8 | Packed active/recovery counts, drive 0 |
| drv1_cycle_byte | output | 8 | Packed active/recovery counts, drive 1 |
| misc_byte | output | 8 | Shared setup, ready count and prefetch enable |

## Verification
The bench aims at the exact-multiple edge, where 100 ns at 10 MHz must give one clock; a design that always adds one, or truncates instead of rounding up, is off by one there or at 101 ns. It drives cycle times shorter than setup plus active. A design that wraps the unsigned difference would report recovery 17 instead of 2. It pushes every field past both ends of its window and drives a detached drive with large values, which catches missing clamps and a detached drive leaking into the shared setup maximum. It also places the larger setup on each drive in turn, so that a design taking one drive's setup instead of the maximum fails. Input changes without `start` catch outputs that follow the inputs, and the `done` timing checks catch an extra or missing pipeline stage.

// File: rtl/ns_enc_pkg.sv
package ns_enc_pkg;
    localparam int SETUP_MIN  = 1;
    localparam int SETUP_MAX  = 4;
    localparam int ACT_MIN    = 1;
    localparam int ACT_MAX    = 16;
    localparam int REC_MIN    = 2;
    localparam int REC_MAX    = 17;
    localparam int NUM_DRIVES = 2;
    localparam int ROUND_DIV  = 1000;

    localparam int SETUP_W = $clog2(SETUP_MAX + 1);
    localparam int ACT_W   = $clog2(ACT_MAX + 1);
    localparam int REC_W   = $clog2(REC_MAX + 1);

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [ACT_W-1:0]   active;
        logic [REC_W-1:0]   recovery;
    } clk_counts_t;
endpackage

// File: rtl/ns_ceil_clk.sv
module ns_ceil_clk #(
    parameter int NS_W      = 16,
    parameter int MHZ_W     = 8,
    parameter int MIN_CLK   = 1,
    parameter int MAX_CLK   = 4,
    parameter int OUT_W     = 3,
    parameter int ROUND_DIV = 1000
) (
    input  logic [NS_W-1:0]  time_ns,
    input  logic [MHZ_W-1:0] mhz,
    output logic [OUT_W-1:0] clocks
);
    // one spare bit so the rounding offset never overflows the product
    localparam int SUM_W = NS_W + MHZ_W + 1;

    logic [SUM_W-1:0] prod;
    logic [SUM_W-1:0] quot;

    always_comb begin
        prod = SUM_W'(time_ns) * SUM_W'(mhz);
        quot = (prod + SUM_W'(ROUND_DIV - 1)) / SUM_W'(ROUND_DIV);
        if (quot < SUM_W'(MIN_CLK)) begin
            clocks = OUT_W'(MIN_CLK);
        end else if (quot > SUM_W'(MAX_CLK)) begin
            clocks = OUT_W'(MAX_CLK);
        end else begin
            clocks = quot[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/drive_clk_calc.sv
module drive_clk_calc
    import ns_enc_pkg::*;
#(
    parameter int NS_W  = 16,
    parameter int MHZ_W = 8
) (
    input  logic             present,
    input  logic [NS_W-1:0]  setup_ns,
    input  logic [NS_W-1:0]  active_ns,
    input  logic [NS_W-1:0]  cycle_ns,
    input  logic [MHZ_W-1:0] mhz,
    output clk_counts_t      counts
);
    localparam int DIFF_W = NS_W + 2;

    logic signed [DIFF_W-1:0] rem_s;
    logic [NS_W-1:0]          rec_ns;
    logic [SETUP_W-1:0]       setup_clk;
    logic [ACT_W-1:0]         active_clk;
    logic [REC_W-1:0]         rec_clk;

    // remainder of the cycle; a negative value saturates to zero
    always_comb begin
        rem_s  = $signed({2'b00, cycle_ns}) - $signed({2'b00, setup_ns})
               - $signed({2'b00, active_ns});
        rec_ns = rem_s[DIFF_W-1] ? '0 : rem_s[NS_W-1:0];
    end

    ns_ceil_clk #(.NS_W(NS_W), .MHZ_W(MHZ_W), .MIN_CLK(SETUP_MIN),
                  .MAX_CLK(SETUP_MAX), .OUT_W(SETUP_W), .ROUND_DIV(ROUND_DIV))
        u_setup (.time_ns(setup_ns), .mhz(mhz), .clocks(setup_clk));

    ns_ceil_clk #(.NS_W(NS_W), .MHZ_W(MHZ_W), .MIN_CLK(ACT_MIN),
                  .MAX_CLK(ACT_MAX), .OUT_W(ACT_W), .ROUND_DIV(ROUND_DIV))
        u_active (.time_ns(active_ns), .mhz(mhz), .clocks(active_clk));

    ns_ceil_clk #(.NS_W(NS_W), .MHZ_W(MHZ_W), .MIN_CLK(REC_MIN),
                  .MAX_CLK(REC_MAX), .OUT_W(REC_W), .ROUND_DIV(ROUND_DIV))
        u_recov (.time_ns(rec_ns), .mhz(mhz), .clocks(rec_clk));

    always_comb begin
        if (present) begin
            counts.setup    = setup_clk;
            counts.active   = active_clk;
            counts.recovery = rec_clk;
        end else begin
            counts.setup    = SETUP_W'(SETUP_MIN);
            counts.active   = ACT_W'(ACT_MIN);
            counts.recovery = REC_W'(REC_MIN);
        end
    end
endmodule

// File: rtl/ns_timing_encoder.sv
module ns_timing_encoder
    import ns_enc_pkg::*;
#(
    parameter int   NS_W        = 16,
    parameter int   MHZ_W       = 8,
    parameter bit   PREFETCH_EN = 1'b1,
    parameter int   READY_CLKS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MHZ_W-1:0] bus_mhz,
    input  logic             drv0_present,
    input  logic [NS_W-1:0]  drv0_setup_ns,
    input  logic [NS_W-1:0]  drv0_active_ns,
    input  logic [NS_W-1:0]  drv0_cycle_ns,
    input  logic             drv1_present,
    input  logic [NS_W-1:0]  drv1_setup_ns,
    input  logic [NS_W-1:0]  drv1_active_ns,
    input  logic [NS_W-1:0]  drv1_cycle_ns,
    output logic             done,
    output logic [7:0]       drv0_cycle_byte,
    output logic [7:0]       drv1_cycle_byte,
    output logic [7:0]       misc_byte
);
    localparam logic [2:0] READY_FIELD = 3'(READY_CLKS - 2);

    typedef struct packed {
        clk_counts_t [NUM_DRIVES-1:0] cnt;
        logic                         v1;
        logic [NUM_DRIVES-1:0][7:0]   cyc;
        logic [7:0]                   misc;
        logic                         done;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_DRIVES-1:0] pres_in;
    logic [NS_W-1:0]       setup_in  [NUM_DRIVES];
    logic [NS_W-1:0]       active_in [NUM_DRIVES];
    logic [NS_W-1:0]       cycle_in  [NUM_DRIVES];
    clk_counts_t           cnt_now   [NUM_DRIVES];

    assign pres_in      = {drv1_present, drv0_present};
    assign setup_in[0]  = drv0_setup_ns;
    assign setup_in[1]  = drv1_setup_ns;
    assign active_in[0] = drv0_active_ns;
    assign active_in[1] = drv1_active_ns;
    assign cycle_in[0]  = drv0_cycle_ns;
    assign cycle_in[1]  = drv1_cycle_ns;

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
        drive_clk_calc #(.NS_W(NS_W), .MHZ_W(MHZ_W)) u_calc (
            .present  (pres_in[g]),
            .setup_ns (setup_in[g]),
            .active_ns(active_in[g]),
            .cycle_ns (cycle_in[g]),
            .mhz      (bus_mhz),
            .counts   (cnt_now[g])
        );
    end

    logic [SETUP_W-1:0] ax;
    logic [SETUP_W-1:0] ax_m1;
    logic [ACT_W-1:0]   act_m1;
    logic [REC_W-1:0]   rec_m2;

    always_comb begin
        st_d = st_q;

        // stage 1: capture clamped counts on start
        st_d.v1 = start;
        if (start) begin
            for (int i = 0; i < NUM_DRIVES; i++) begin
                st_d.cnt[i] = cnt_now[i];
            end
        end

        // stage 2: merge setup and pack bytes
        ax = st_q.cnt[0].setup;
        for (int i = 1; i < NUM_DRIVES; i++) begin
            if (st_q.cnt[i].setup > ax) ax = st_q.cnt[i].setup;
        end
        ax_m1  = ax - SETUP_W'(1);
        act_m1 = '0;
        rec_m2 = '0;

        st_d.done = st_q.v1;
        if (st_q.v1) begin
            for (int i = 0; i < NUM_DRIVES; i++) begin
                act_m1     = st_q.cnt[i].active - ACT_W'(1);
                rec_m2     = st_q.cnt[i].recovery - REC_W'(2);
                st_d.cyc[i] = {act_m1[3:0], rec_m2[3:0]};
            end
            st_d.misc = {1'b0, PREFETCH_EN, ax_m1[1:0], READY_FIELD, 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done            = st_q.done;
    assign drv0_cycle_byte = st_q.cyc[0];
    assign drv1_cycle_byte = st_q.cyc[1];
    assign misc_byte       = st_q.misc;

    // clamp windows seen at the pipeline register
    assert_setup_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v1 |-> (st_q.cnt[0].setup >= 1 && st_q.cnt[0].setup <= 4 &&
                     st_q.cnt[1].setup >= 1 && st_q.cnt[1].setup <= 4));

    assert_active_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v1 |-> (st_q.cnt[0].active >= 1 && st_q.cnt[0].active <= 16 &&
                     st_q.cnt[1].active >= 1 && st_q.cnt[1].active <= 16));

    assert_recovery_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v1 |-> (st_q.cnt[0].recovery >= 2 && st_q.cnt[0].recovery <= 17 &&
                     st_q.cnt[1].recovery >= 2 && st_q.cnt[1].recovery <= 17));

    assert_absent_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !drv0_present) |=>
            (st_q.cnt[0].setup == 1 && st_q.cnt[0].active == 1 &&
             st_q.cnt[0].recovery == 2));

    assert_misc_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_byte[7] == 1'b0 && misc_byte[0] == 1'b0));

    assert_done_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2));

    assert_hold_outputs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(misc_byte) && $stable(drv0_cycle_byte) &&
                   $stable(drv1_cycle_byte)));
endmodule

// File: tb/ns_timing_encoder_test.sv
module ns_timing_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  bus_mhz = '0;
    logic        p0 = 1'b0, p1 = 1'b0;
    logic [15:0] s0 = '0, a0 = '0, c0 = '0, s1 = '0, a1 = '0, c1 = '0;
    logic        done;
    logic [7:0]  cb0, cb1, misc;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] last_cb0 = '0, last_cb1 = '0, last_misc = '0;

    always #10 clk = ~clk;  // 50 MHz

    ns_timing_encoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz),
        .drv0_present(p0), .drv0_setup_ns(s0), .drv0_active_ns(a0), .drv0_cycle_ns(c0),
        .drv1_present(p1), .drv1_setup_ns(s1), .drv1_active_ns(a1), .drv1_cycle_ns(c1),
        .done(done), .drv0_cycle_byte(cb0), .drv1_cycle_byte(cb1), .misc_byte(misc)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int cclk(int ns, int mhz, int lo, int hi);
        int q = (ns * mhz + 999) / 1000;
        if (q < lo) q = lo;
        if (q > hi) q = hi;
        return q;
    endfunction

    // model of one drive: returns {setup, cycle byte}
    function automatic void model(bit pr, int su, int ac, int cy, int mhz,
                                  output int su_c, output int byte_o);
        int ac_c, rc_c, rem;
        if (pr) begin
            su_c = cclk(su, mhz, 1, 4);
            ac_c = cclk(ac, mhz, 1, 16);
            rem  = cy - su - ac;
            if (rem < 0) rem = 0;
            rc_c = cclk(rem, mhz, 2, 17);
        end else begin
            su_c = 1; ac_c = 1; rc_c = 2;
        end
        byte_o = ((ac_c - 1) << 4) | (rc_c - 2);
    endfunction

    task automatic run_case(string req, int mhz,
                            bit pr0, int su0, int ac0, int cy0,
                            bit pr1, int su1, int ac1, int cy1);
        int sa, sb, ba, bb, ax, em;
        model(pr0, su0, ac0, cy0, mhz, sa, ba);
        model(pr1, su1, ac1, cy1, mhz, sb, bb);
        ax = (sa > sb) ? sa : sb;
        em = 8'h40 | ((ax - 1) << 4);
        @(negedge clk);
        bus_mhz = 8'(mhz);
        p0 = pr0; s0 = 16'(su0); a0 = 16'(ac0); c0 = 16'(cy0);
        p1 = pr1; s1 = 16'(su1); a1 = 16'(ac1); c1 = 16'(cy1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R10 done early"}, int'(done), 0);
        @(negedge clk);
        check({req, " R10 done"}, int'(done), 1);
        check({req, " R8 drive0 byte"}, int'(cb0), ba);
        check({req, " R8 drive1 byte"}, int'(cb1), bb);
        check({req, " R9 misc byte"}, int'(misc), em);
        last_cb0 = cb0; last_cb1 = cb1; last_misc = misc;
        @(negedge clk);
        check({req, " R10 done single"}, int'(done), 0);
    endtask

    task automatic test_reset();
        check("R11 done", int'(done), 0);
        check("R11 drive0", int'(cb0), 0);
        check("R11 drive1", int'(cb1), 0);
        check("R11 misc", int'(misc), 0);
    endtask

    task automatic test_ignore();
        // R12: inputs move without start; outputs must hold
        @(negedge clk);
        bus_mhz = 8'd200; p0 = 1; p1 = 1;
        s0 = 16'd900; a0 = 16'd900; c0 = 16'd9000;
        s1 = 16'd5;   a1 = 16'd5;   c1 = 16'd10;
        repeat (4) @(negedge clk);
        check("R12 done", int'(done), 0);
        check("R12 drive0", int'(cb0), int'(last_cb0));
        check("R12 drive1", int'(cb1), int'(last_cb1));
        check("R12 misc", int'(misc), int'(last_misc));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        // R1 nominal: 80 ns at 40 MHz -> 4 clocks; drive1 absent (R6)
        run_case("R1 nominal", 40, 1, 30, 80, 300, 0, 0, 0, 0);
        // R1 exact multiple and one above
        run_case("R1 exact", 10, 1, 100, 100, 300, 1, 101, 101, 303);
        // R3 setup clamp high and low, R7 max on drive1
        run_case("R3 R7 setup", 33, 1, 0, 60, 200, 1, 500, 60, 900);
        // R7 max on drive0
        run_case("R7 max drive0", 50, 1, 70, 100, 400, 1, 10, 100, 400);
        // R4 active clamp high and low
        run_case("R4 active", 66, 1, 20, 1000, 1100, 1, 20, 0, 100);
        // R5 recovery clamp high; R2 negative remainder -> 2
        run_case("R5 R2 recovery", 100, 1, 10, 50, 5000, 1, 300, 300, 100);
        // R6 absent drive with large values does not raise shared setup
        run_case("R6 absent", 25, 0, 60000, 60000, 60000, 1, 40, 120, 600);
        // R1 wide product without overflow
        run_case("R1 wide", 255, 1, 65535, 65535, 65535, 1, 1, 1, 65535);
        test_ignore();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule